// File: doc/BRIEF.md
# E1 Overhead Bit Multiframe Collector

This block sits behind an E1 framer on the receive side. It collects the overhead bits carried in time slot 0 across one CRC-4 multiframe. These are the international bit of alignment frames, the international bit of non-alignment frames, the remote alarm bit and the five national bits Sa4 to Sa8. The framer hands over one time slot 0 octet per frame. With each octet it marks whether the frame is an alignment or a non-alignment frame, and it gives the frame's number (0 to 15) inside the multiframe.

Each of the eight overhead positions has its own shift register. The earliest bit ends up in the MSB after the eight frames of its type. When the octet for frame 15 is accepted, all eight registers are copied together into holding registers that the host can read, and a sticky multiframe flag is set. The host then has one multiframe (2 ms) to read the holding registers before they are overwritten. If a new update arrives while the flag is still set, an overrun flag is raised. A loss-of-multiframe-alignment input blocks the update.

The octet input is a valid/ready stream. The block never applies back-pressure: `ts0_ready` is low only during reset, so the framer can treat every octet offered outside reset as taken. The host side is a plain single-cycle register port with a combinational read. Reading the status register clears it, and writing ones to it clears the matching bits.

Top module: `e1ovh_capture`

## Requirements
- R1: `ts0_ready` is 0 while `rst_n` is low and 1 otherwise, so every octet offered with `ts0_valid` outside reset is accepted.
- R2: For an accepted octet with `ts0_nfas`=0 (alignment frame), bit 7 shifts into register address 0. After eight such octets, the earliest one is in bit 7 of that register.
- R3: For an accepted octet with `ts0_nfas`=1 (non-alignment frame), bit 7 shifts into address 1 and bit 5 shifts into address 2, both earliest-bit-at-MSB.
- R4: For an accepted non-alignment octet, bits 4, 3, 2, 1 and 0 shift into addresses 3, 4, 5, 6 and 7 respectively (Sa4 to Sa8), earliest-bit-at-MSB.
- R5: Holding registers change only on the clock edge that accepts an octet with `ts0_frame`=15 and `mf_lost`=0. The values they then take include that octet's bits.
- R6: Status address 8, bit 0, is the multiframe flag. It is set by every update. It is cleared by a host read of address 8, or by a host write to address 8 with data bit 0 set. When an update and a clear fall in the same cycle, the update wins.
- R7: Status bit 1 is the overrun flag. It is set when an update occurs while the multiframe flag is set and is not being cleared in that cycle. It is cleared by a read of address 8, or by a write to address 8 with data bit 1 set.
- R8: While `mf_lost` is 1, an octet with `ts0_frame`=15 updates no holding register and sets no status bit.
- R9: After reset, all holding registers and both status bits read 0.
- R10: Addresses 9 to 15 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ts0_valid | input | 1 | Time slot 0 octet offered |
| ts0_ready | output | 1 | Octet accepted (high outside reset) |
| ts0_data | input | 8 | Time slot 0 octet, bit 7 received first |
| ts0_nfas | input | 1 | 1 = non-alignment frame, 0 = alignment frame |
| ts0_frame | input | 4 | Frame number inside the CRC-4 multiframe |
| mf_lost | input | 1 | Loss of multiframe alignment; blocks updates |
| host_rd | input | 1 | Host read strobe (clears status when address is 8) |
| host_wr | input | 1 | Host write strobe |
| host_addr | input | 4 | Host register address |
| host_wdata | input | 8 | Host write data (write-one-to-clear on status) |
| host_rdata | output | 8 | Combinational read data for `host_addr` |

## Verification
The colliding pair is the multiframe update and the host's status clear. The bench lines up the octet for frame 15 with a read of address 8, with a write of 1 to bit 0, and with a write of 2 to bit 1. The flag must survive each of these collisions. The overrun flag must stay clear when the flag is being cleared in that same cycle, and must be set when only the overrun bit is written. A behavioural model in the bench predicts the read data on every clock, so the outcome is judged both at the edge of the collision and in the cycles after it.

// File: rtl/e1ovh_pkg.sv
package e1ovh_pkg;
  localparam int OCT_W       = 8;
  localparam int NUM_SA      = 5;
  localparam int NUM_REG     = 3 + NUM_SA;
  localparam int FRAMES      = 16;
  localparam int FRAME_W     = $clog2(FRAMES);
  localparam int REG_W       = FRAMES / 2;
  localparam int ADDR_W      = 4;
  localparam int ADDR_STATUS = NUM_REG;
  localparam int IDX_SI_FAS  = 0;
  localparam int IDX_SI_NFAS = 1;
  localparam int IDX_ALARM   = 2;
  localparam int IDX_SA0     = 3;
  localparam int POS_SI      = OCT_W - 1;
  localparam int POS_ALARM   = NUM_SA;
endpackage

// File: rtl/e1ovh_route.sv
module e1ovh_route
  import e1ovh_pkg::*;
(
  input  logic               accept,
  input  logic               nfas,
  input  logic [OCT_W-1:0]   data,
  output logic [NUM_REG-1:0] en,
  output logic [NUM_REG-1:0] bits
);
  always_comb begin
    en   = '0;
    bits = '0;
    en[IDX_SI_FAS]    = accept & ~nfas;
    bits[IDX_SI_FAS]  = data[POS_SI];
    en[IDX_SI_NFAS]   = accept & nfas;
    bits[IDX_SI_NFAS] = data[POS_SI];
    en[IDX_ALARM]     = accept & nfas;
    bits[IDX_ALARM]   = data[POS_ALARM];
    for (int i = 0; i < NUM_SA; i++) begin
      en[IDX_SA0+i]   = accept & nfas;
      bits[IDX_SA0+i] = data[NUM_SA-1-i];
    end
  end
endmodule

// File: rtl/e1ovh_shift.sv
module e1ovh_shift #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         shift_en,
  input  logic         bit_in,
  input  logic         publish,
  output logic [W-1:0] hold
);
  logic [W-1:0] sr, sr_next;

  assign sr_next = shift_en ? {sr[W-2:0], bit_in} : sr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr   <= '0;
      hold <= '0;
    end else begin
      sr <= sr_next;
      if (publish) hold <= sr_next;
    end
  end
endmodule

// File: rtl/e1ovh_status.sv
module e1ovh_status (
  input  logic clk,
  input  logic rst_n,
  input  logic publish,
  input  logic clr_flag,
  input  logic clr_ovr,
  output logic flag,
  output logic ovr
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag <= 1'b0;
      ovr  <= 1'b0;
    end else begin
      flag <= (flag & ~clr_flag) | publish;
      ovr  <= (ovr & ~clr_ovr) | (publish & flag & ~clr_flag);
    end
  end
endmodule

// File: rtl/e1ovh_capture.sv
module e1ovh_capture
  import e1ovh_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               ts0_valid,
  output logic               ts0_ready,
  input  logic [OCT_W-1:0]   ts0_data,
  input  logic               ts0_nfas,
  input  logic [FRAME_W-1:0] ts0_frame,
  input  logic               mf_lost,
  input  logic               host_rd,
  input  logic               host_wr,
  input  logic [ADDR_W-1:0]  host_addr,
  input  logic [OCT_W-1:0]   host_wdata,
  output logic [OCT_W-1:0]   host_rdata
);
  logic                     accept, publish, st_sel, clr_flag, clr_ovr;
  logic                     st_flag, st_ovr;
  logic [NUM_REG-1:0]       sh_en, sh_bit;
  logic [REG_W-1:0]         hold [NUM_REG];
  logic [NUM_REG*REG_W-1:0] hold_flat;

  assign ts0_ready = rst_n;
  assign accept    = ts0_valid & ts0_ready;
  assign publish   = accept & ~mf_lost & (ts0_frame == FRAME_W'(FRAMES - 1));
  assign st_sel    = (host_addr == ADDR_W'(ADDR_STATUS));
  assign clr_flag  = st_sel & (host_rd | (host_wr & host_wdata[0]));
  assign clr_ovr   = st_sel & (host_rd | (host_wr & host_wdata[1]));

  e1ovh_route u_route (
    .accept (accept),
    .nfas   (ts0_nfas),
    .data   (ts0_data),
    .en     (sh_en),
    .bits   (sh_bit)
  );

  for (genvar k = 0; k < NUM_REG; k++) begin : g_reg
    e1ovh_shift #(.W(REG_W)) u_shift (
      .clk      (clk),
      .rst_n    (rst_n),
      .shift_en (sh_en[k]),
      .bit_in   (sh_bit[k]),
      .publish  (publish),
      .hold     (hold[k])
    );
    assign hold_flat[k*REG_W +: REG_W] = hold[k];
  end

  e1ovh_status u_status (
    .clk      (clk),
    .rst_n    (rst_n),
    .publish  (publish),
    .clr_flag (clr_flag),
    .clr_ovr  (clr_ovr),
    .flag     (st_flag),
    .ovr      (st_ovr)
  );

  always_comb begin
    host_rdata = '0;
    for (int i = 0; i < NUM_REG; i++)
      if (host_addr == ADDR_W'(i)) host_rdata = hold[i];
    if (st_sel) begin
      host_rdata[0] = st_flag;
      host_rdata[1] = st_ovr;
    end
  end
endmodule

// File: rtl/e1ovh_capture_chk.sv
module e1ovh_capture_chk
  import e1ovh_pkg::*;
(
  input logic                     clk,
  input logic                     rst_n,
  input logic                     ts0_valid,
  input logic                     ts0_ready,
  input logic [FRAME_W-1:0]       ts0_frame,
  input logic                     mf_lost,
  input logic                     host_rd,
  input logic                     host_wr,
  input logic [ADDR_W-1:0]        host_addr,
  input logic [OCT_W-1:0]         host_wdata,
  input logic [NUM_REG*REG_W-1:0] hold_flat,
  input logic                     st_flag,
  input logic                     st_ovr
);
  logic acc_c, last_c, upd_c, fclr_c;
  assign acc_c  = ts0_valid && ts0_ready;
  assign last_c = (ts0_frame == FRAME_W'(FRAMES - 1));
  assign upd_c  = acc_c && last_c && !mf_lost;
  assign fclr_c = (host_addr == ADDR_W'(ADDR_STATUS)) &&
                  (host_rd || (host_wr && host_wdata[0]));

  AST_HOLD_ONLY_AT_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
    !upd_c |=> $stable(hold_flat)); // R5
  AST_LOSS_NO_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_c && last_c && mf_lost && !st_flag) |=> !st_flag); // R8
  AST_FLAG_ON_UPDATE: assert property (@(posedge clk) disable iff (!rst_n)
    upd_c |=> st_flag); // R6
  AST_FLAG_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (fclr_c && !upd_c) |=> !st_flag); // R6
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_c && st_flag && !fclr_c) |=> st_ovr); // R7
  AST_OVR_NEEDS_UPDATE: assert property (@(posedge clk) disable iff (!rst_n)
    (!upd_c && !st_ovr) |=> !st_ovr); // R7
endmodule

bind e1ovh_capture e1ovh_capture_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .ts0_valid  (ts0_valid),
  .ts0_ready  (ts0_ready),
  .ts0_frame  (ts0_frame),
  .mf_lost    (mf_lost),
  .host_rd    (host_rd),
  .host_wr    (host_wr),
  .host_addr  (host_addr),
  .host_wdata (host_wdata),
  .hold_flat  (hold_flat),
  .st_flag    (st_flag),
  .st_ovr     (st_ovr)
);

// File: tb/e1ovh_capture_test.sv
`timescale 1ns/1ps
module e1ovh_capture_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ts0_valid = 1'b0, ts0_nfas = 1'b0, mf_lost = 1'b0;
  logic [7:0] ts0_data = '0, host_wdata = '0;
  logic [3:0] ts0_frame = '0, host_addr = '0;
  logic       host_rd = 1'b0, host_wr = 1'b0;
  logic       ts0_ready;
  logic [7:0] host_rdata;

  int checks = 0, failures = 0, mon = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  e1ovh_capture uut (.*);

  // behavioural reference
  bit     q [8][$];
  int     hold_m [8];
  bit     flag_m, ovr_m;

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int k = 0; k < 8; k++) begin q[k].delete(); hold_m[k] = 0; end
      flag_m = 0; ovr_m = 0;
    end else begin
      bit acc, pub, cf, co, f;
      acc = ts0_valid;
      pub = acc && ts0_frame == 15 && !mf_lost;
      cf  = host_addr == 8 && (host_rd || (host_wr && host_wdata[0]));
      co  = host_addr == 8 && (host_rd || (host_wr && host_wdata[1]));
      if (acc) begin
        if (!ts0_nfas) q[0].push_back(ts0_data[7]);
        else begin
          q[1].push_back(ts0_data[7]);
          q[2].push_back(ts0_data[5]);
          for (int i = 0; i < 5; i++) q[3+i].push_back(ts0_data[4-i]);
        end
        for (int k = 0; k < 8; k++) while (q[k].size() > 8) void'(q[k].pop_front());
      end
      if (pub)
        for (int k = 0; k < 8; k++) begin
          int v; v = 0;
          foreach (q[k][j]) v = v * 2 + q[k][j];
          hold_m[k] = v;
        end
      f = flag_m;
      flag_m = (f && !cf) || pub;
      ovr_m  = (ovr_m && !co) || (pub && f && !cf);
    end
  end

  function automatic int model_rd(input int a);
    if (a < 8) return hold_m[a];
    if (a == 8) return {ovr_m, flag_m};
    return 0;
  endfunction

  function automatic string tag_of(input int a);
    if (a == 0) return "R2";
    if (a < 3) return "R3";
    if (a < 8) return "R4";
    if (a == 8) return "R6/R7";
    return "R10";
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  // advance one clock; compare against the model after the edge
  task automatic tick();
    @(posedge clk);
    @(negedge clk);
    chk("R1 ready", ts0_ready, rst_n);
    chk(tag_of(host_addr), host_rdata, model_rd(host_addr));
  endtask

  task automatic direct_rd(input int a, input int exp, input string tag);
    host_addr = a[3:0]; host_rd = 1'b1;
    #1 chk(tag, host_rdata, exp);
    tick();
    host_rd = 1'b0;
  endtask

  // one multiframe; pk holds the eight register bytes, address 0 in the top byte
  task automatic send_mf(input logic [63:0] pk, input bit lost_last,
                         input bit rd_last, input bit wr_last, input logic [7:0] wd_last);
    for (int f = 0; f < 16; f++) begin
      int j; j = f / 2;
      if (f % 2 == 0) ts0_data = {pk[63-j], 7'b0011011};
      else begin
        ts0_data[7] = pk[55-j];
        ts0_data[6] = 1'b1;
        ts0_data[5] = pk[47-j];
        for (int i = 0; i < 5; i++) ts0_data[4-i] = pk[39-8*i-j];
      end
      ts0_valid = 1'b1; ts0_nfas = f[0]; ts0_frame = f[3:0];
      mf_lost = (f == 15) && lost_last;
      if (f == 15 && (rd_last || wr_last)) begin
        host_addr = 8; host_rd = rd_last; host_wr = wr_last; host_wdata = wd_last;
        #1 chk("R6 collision read", host_rdata, model_rd(8));
      end else begin
        host_addr = mon[3:0]; mon = (mon + 1) % 10;
      end
      tick();
      ts0_valid = 1'b0; mf_lost = 1'b0; host_rd = 1'b0; host_wr = 1'b0;
      if (f % 5 == 2) tick();
    end
  endtask

  task automatic host_write(input int d);
    host_addr = 8; host_wr = 1'b1; host_wdata = d[7:0];
    tick();
    host_wr = 1'b0;
  endtask

  localparam logic [63:0] PAT_A = 64'hA5_3C_F0_81_42_24_18_FF;

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [63:0] rnd;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1 ready in reset", ts0_ready, 0);
    for (int a = 0; a < 9; a++) begin
      host_addr = a[3:0]; #1 chk("R9 reset value", host_rdata, 0);
    end
    rst_n = 1'b1;
    tick();

    // known pattern, bit placement per register
    send_mf(PAT_A, 0, 0, 0, 8'h00);
    for (int a = 0; a < 8; a++)
      direct_rd(a, PAT_A[63-8*a -: 8], a == 0 ? "R2" : (a < 3 ? "R3" : "R4"));
    chk("R5 last octet is LSB of Sa8", host_rdata, 8'hFF);
    direct_rd(8, 1, "R6 flag after update");
    direct_rd(8, 0, "R6 flag cleared by read");

    // loss of alignment: no update
    send_mf(64'h0123456789ABCDEF, 1, 0, 0, 8'h00);
    direct_rd(8, 0, "R8 no flag when lost");
    direct_rd(0, 8'hA5, "R8 hold kept when lost");
    direct_rd(7, 8'hFF, "R5 hold kept when lost");

    // two updates without service: overrun
    rnd = {$urandom, $urandom}; send_mf(rnd, 0, 0, 0, 8'h00);
    rnd = {$urandom, $urandom}; send_mf(rnd, 0, 0, 0, 8'h00);
    direct_rd(3, rnd[39:32], "R4 second update value");
    direct_rd(8, 3, "R7 overrun set");
    direct_rd(8, 0, "R7 overrun cleared by read");

    // collisions of update with status clear
    send_mf({$urandom, $urandom}, 0, 0, 0, 8'h00);
    send_mf({$urandom, $urandom}, 0, 1, 0, 8'h00);
    direct_rd(8, 1, "R6/R7 read collides with update");
    send_mf({$urandom, $urandom}, 0, 0, 1, 8'h01);
    host_addr = 8; #1 chk("R6/R7 W1C flag collides with update", host_rdata, 1);
    send_mf({$urandom, $urandom}, 0, 0, 1, 8'h02);
    host_addr = 8; #1 chk("R7 W1C ovr only, overrun set", host_rdata, 3);
    host_write(2);
    host_addr = 8; #1 chk("R7 W1C clears overrun only", host_rdata, 1);
    host_write(1);
    host_addr = 8; #1 chk("R6 W1C clears flag", host_rdata, 0);

    for (int a = 9; a < 16; a++) begin
      host_addr = a[3:0]; #1 chk("R10 unused address", host_rdata, 0);
    end
    tick();

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule